// File: doc/BRIEF.md
# Phase-Frequency Detector with Steering

This block compares a feedback signal with a reference signal and produces a three-level drive command for a phase-locked control loop. Both inputs are asynchronous. Each one passes through a synchronizer and an edge detector running on the system clock, and only the detected edges move a ten-state ring. Feedback edges step the ring one way and reference edges step it the other way. Four states carry pure phase error. In one state of each pair the output is driven up or down, and in the other it rests at the middle level. When the feedback is faster, the ring reaches saturating frequency-error states that keep the output at full drive up. A faster reference gives the mirror case, full drive down. This steering gives a fast pull-in before phase tracking starts.

A lock flag is decoded from the ring position. It is true only in the four phase-error states. A double-edge enable makes falling feedback edges count as well as rising ones, which doubles the comparison rate on the feedback side. A debug output exposes the current state number, 1 to 10.

Top module: `pfd_steer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the state number is 6, `drv_mid` is 1, `drv_up` and `drv_dn` are 0, and `locked` is 1.
- R2: Exactly one of `drv_up`, `drv_dn`, `drv_mid` is high in every cycle. Drive is up in states 5, 7, 8 and 9, down in states 2, 3, 4 and 10, and middle in states 1 and 6.
- R3: A feedback rising edge in state 6 moves the state to 7 (drive up), and a reference rising edge then returns it to 6 (middle). The state updates on the third rising clock edge after the input changes.
- R4: A reference rising edge in state 6 moves the state to 1 (middle), a second one moves it to 2 (drive down), and a feedback edge from 2 returns it to 1.
- R5: Feedback edges walk the state from 1 through 6, 7 and 8 to 9, and 9 saturates. In states 9, 8 and 5 a reference edge moves the state 9→8→5→6. A feedback edge moves 5 back to 8.
- R6: Reference edges walk the state from 6 through 1, 2 and 3 to 4, and 4 saturates. A feedback edge moves the state 4→3→10→1, and a reference edge moves 10 back to 3.
- R7: `locked` is 1 exactly when the state number is 1, 2, 6 or 7.
- R8: A feedback event and a reference event detected in the same clock cycle cancel each other, and the state does not change.
- R9: With `dbl_edge` at 0, a falling feedback edge has no effect. With `dbl_edge` at 1, a falling feedback edge steps the state like a rising one. Reference falling edges never count.
- R10: The state number is always in the range 1 to 10, and with no detected event it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_in | input | 1 | Feedback (plus) signal, asynchronous |
| ref_in | input | 1 | Reference (minus) signal, asynchronous |
| dbl_edge | input | 1 | 1: falling feedback edges also count |
| drv_up | output | 1 | Drive output to the high level |
| drv_dn | output | 1 | Drive output to the low level |
| drv_mid | output | 1 | Output at the middle, high-impedance level |
| locked | output | 1 | 1 when in a phase-error state |
| state_idx | output | 4 | Current state number, 1 to 10 |

## Verification
The crossover states 5 and 10 are the hardest to reach. They can only be entered from a frequency-error state, and that takes at least two more edges of one input than the other, followed by a run of edges in the opposite direction. The bench builds this path by sending discrete, well-separated pulses on one input until the ring saturates. It then sends single pulses on the other input and checks every state along the way. Cancellation is reached by raising both inputs on the same clock cycle, so that both edges are detected together.

// File: rtl/pfd_steer.sv
module pfd_steer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fb_in,
  input  logic       ref_in,
  input  logic       dbl_edge,
  output logic       drv_up,
  output logic       drv_dn,
  output logic       drv_mid,
  output logic       locked,
  output logic [3:0] state_idx
);

  localparam int SHW = SYNC_STAGES + 1;

  logic [SHW-1:0] fb_sh, ref_sh;
  logic           p_ev, m_ev;
  logic [3:0]     st, st_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_sh  <= '0;
      ref_sh <= '0;
    end else begin
      fb_sh  <= {fb_sh[SHW-2:0], fb_in};
      ref_sh <= {ref_sh[SHW-2:0], ref_in};
    end
  end

  wire fb_rise  = fb_sh[SHW-2] & ~fb_sh[SHW-1];
  wire fb_fall  = ~fb_sh[SHW-2] & fb_sh[SHW-1];
  wire ref_rise = ref_sh[SHW-2] & ~ref_sh[SHW-1];

  assign p_ev = fb_rise | (dbl_edge & fb_fall);
  assign m_ev = ref_rise;

  always_comb begin
    st_nx = st;
    if (p_ev && !m_ev) begin
      case (st)
        4'd4:  st_nx = 4'd3;
        4'd3:  st_nx = 4'd10;
        4'd10: st_nx = 4'd1;
        4'd2:  st_nx = 4'd1;
        4'd1:  st_nx = 4'd6;
        4'd6:  st_nx = 4'd7;
        4'd7:  st_nx = 4'd8;
        4'd5:  st_nx = 4'd8;
        4'd8:  st_nx = 4'd9;
        4'd9:  st_nx = 4'd9;
        default: st_nx = 4'd6;
      endcase
    end else if (m_ev && !p_ev) begin
      case (st)
        4'd9:  st_nx = 4'd8;
        4'd8:  st_nx = 4'd5;
        4'd5:  st_nx = 4'd6;
        4'd7:  st_nx = 4'd6;
        4'd6:  st_nx = 4'd1;
        4'd1:  st_nx = 4'd2;
        4'd2:  st_nx = 4'd3;
        4'd10: st_nx = 4'd3;
        4'd3:  st_nx = 4'd4;
        4'd4:  st_nx = 4'd4;
        default: st_nx = 4'd6;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= 4'd6;
    else     st <= st_nx;
  end

  assign drv_up    = (st == 4'd5) | (st == 4'd7) | (st == 4'd8) | (st == 4'd9);
  assign drv_dn    = (st == 4'd2) | (st == 4'd3) | (st == 4'd4) | (st == 4'd10);
  assign drv_mid   = (st == 4'd1) | (st == 4'd6);
  assign locked    = (st == 4'd1) | (st == 4'd2) | (st == 4'd6) | (st == 4'd7);
  assign state_idx = st;

endmodule

module pfd_steer_chk (
  input logic       clk,
  input logic       rst,
  input logic       p_ev,
  input logic       m_ev,
  input logic [3:0] st,
  input logic       drv_up,
  input logic       drv_dn,
  input logic       drv_mid,
  input logic       locked
);

  a_r1_reset_state: assert property (@(posedge clk) rst |=> (st == 4'd6 && drv_mid && locked));

  a_r2_one_level: assert property (@(posedge clk) disable iff (rst)
    $onehot({drv_up, drv_dn, drv_mid}));

  a_r5_sat_high: assert property (@(posedge clk) disable iff (rst)
    (st == 4'd9 && !m_ev) |=> (st == 4'd9));

  a_r6_sat_low: assert property (@(posedge clk) disable iff (rst)
    (st == 4'd4 && !p_ev) |=> (st == 4'd4));

  a_r8_cancel: assert property (@(posedge clk) disable iff (rst)
    (p_ev && m_ev) |=> $stable(st));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!p_ev && !m_ev) |=> $stable(st));

  a_r10_range: assert property (@(posedge clk) disable iff (rst)
    (st >= 4'd1 && st <= 4'd10));

  a_r7_lock_err: assert property (@(posedge clk) disable iff (rst)
    (drv_up && !locked) |-> (st != 4'd7));

endmodule

bind pfd_steer pfd_steer_chk u_chk (
  .clk(clk), .rst(rst), .p_ev(p_ev), .m_ev(m_ev), .st(st),
  .drv_up(drv_up), .drv_dn(drv_dn), .drv_mid(drv_mid), .locked(locked)
);

// File: tb/pfd_steer_tb.sv
`timescale 1ns/1ps
module pfd_steer_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_in = 1'b0, ref_in = 1'b0, dbl_edge = 1'b0;
  logic drv_up, drv_dn, drv_mid, locked;
  logic [3:0] state_idx;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pfd_steer u_dut (
    .clk(clk), .rst(rst), .fb_in(fb_in), .ref_in(ref_in), .dbl_edge(dbl_edge),
    .drv_up(drv_up), .drv_dn(drv_dn), .drv_mid(drv_mid), .locked(locked),
    .state_idx(state_idx)
  );

  task automatic chk(input string tag, input int exp_st);
    logic eu, ed, em, el;
    eu = (exp_st == 5 || exp_st == 7 || exp_st == 8 || exp_st == 9);
    ed = (exp_st == 2 || exp_st == 3 || exp_st == 4 || exp_st == 10);
    em = (exp_st == 1 || exp_st == 6);
    el = (exp_st == 1 || exp_st == 2 || exp_st == 6 || exp_st == 7);
    checks++;
    if (int'(state_idx) != exp_st || drv_up != eu || drv_dn != ed ||
        drv_mid != em || locked != el) begin
      errors++;
      $display("FAIL %s: got st=%0d up=%b dn=%b mid=%b lock=%b, expected st=%0d up=%b dn=%b mid=%b lock=%b",
               tag, state_idx, drv_up, drv_dn, drv_mid, locked, exp_st, eu, ed, em, el);
    end
  endtask

  task automatic pulse(input bit p, input bit m);
    @(negedge clk);
    if (p) fb_in = 1'b1;
    if (m) ref_in = 1'b1;
    repeat (5) @(negedge clk);
    fb_in = 1'b0;
    ref_in = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 during reset", 6);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 6);
  endtask

  task automatic t_plus_lead;
    @(negedge clk);
    fb_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 no change before third edge", 6);
    @(negedge clk);
    chk("R3 up on plus edge", 7);
    repeat (4) @(negedge clk);
    fb_in = 1'b0;
    repeat (5) @(negedge clk);
    chk("R3 up held until minus", 7);
    pulse(0, 1);
    chk("R3 middle after minus", 6);
  endtask

  task automatic t_minus_lead;
    pulse(0, 1); chk("R4 first minus to 1", 1);
    pulse(0, 1); chk("R4 second minus drives down", 2);
    pulse(1, 0); chk("R4 plus back to middle", 1);
  endtask

  task automatic t_cancel;
    pulse(1, 1); chk("R8 coincident edges cancel", 1);
  endtask

  task automatic t_plus_fast;
    pulse(1, 0); chk("R5 1 to 6", 6);
    pulse(1, 0); chk("R5 6 to 7", 7);
    pulse(1, 0); chk("R5 7 to 8 freq error", 8);
    pulse(1, 0); chk("R5 8 to 9", 9);
    pulse(1, 0); chk("R5 9 saturates", 9);
    pulse(0, 1); chk("R5 9 to 8", 8);
    pulse(0, 1); chk("R5 8 to crossover 5", 5);
    pulse(1, 0); chk("R5 5 back to 8", 8);
    pulse(0, 1); chk("R5 8 to 5 again", 5);
    pulse(0, 1); chk("R5 R7 5 to 6 relock", 6);
  endtask

  task automatic t_minus_fast;
    pulse(0, 1); chk("R6 6 to 1", 1);
    pulse(0, 1); chk("R6 1 to 2", 2);
    pulse(0, 1); chk("R6 2 to 3 freq error", 3);
    pulse(0, 1); chk("R6 3 to 4", 4);
    pulse(0, 1); chk("R6 4 saturates", 4);
    pulse(1, 0); chk("R6 4 to 3", 3);
    pulse(1, 0); chk("R6 3 to crossover 10", 10);
    pulse(0, 1); chk("R6 10 back to 3", 3);
    pulse(1, 0); chk("R6 3 to 10 again", 10);
    pulse(1, 0); chk("R6 R7 10 to 1 relock", 1);
  endtask

  task automatic t_double_edge;
    dbl_edge = 1'b0;
    @(negedge clk); fb_in = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 rising counts single-edge", 6);
    fb_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 falling ignored single-edge", 6);
    dbl_edge = 1'b1;
    @(negedge clk); fb_in = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 rising counts double-edge", 7);
    fb_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 falling counts double-edge", 8);
    @(negedge clk); ref_in = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 ref rising counts", 5);
    ref_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 ref falling ignored", 5);
    dbl_edge = 1'b0;
  endtask

  initial begin
    t_reset();
    t_plus_lead();
    t_minus_lead();
    t_cancel();
    t_plus_fast();
    t_minus_fast();
    t_double_edge();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule